// File: doc/BRIEF.md
# Channel-Windowed DMA Control Register File

This block holds the software-visible control state of a multi-channel DMA engine. It has twenty channels and four peripheral ports. It does not give each channel its own set of addresses. Instead, software first writes a channel number into a channel selector. Every later access to the channel window then reaches that channel's copy of the poll, control, descriptor base, descriptor count, status and interrupt-enable registers. A second selector works the same way for the per-port control word.

Each channel has a run bit, a transmit-direction bit, a two-bit arbitration weight, polling settings and a descriptor ring base and length. It also has six status bits, which the datapath sets through a per-channel event input. A channel reset bit clears itself after a fixed number of cycles, so software can poll it. A global clear command wipes every channel at once. The status of every channel is masked by that channel's enables and then by a per-channel node mask. The results are combined into one interrupt line. A constant identification word reports the revision, the port count and the channel count.

Top module: `dmac_regwin`

## Requirements
- R1: Reading offset 0x08 returns the identification word: revision in bits 4:0, port count (4) in bits 19:16, channel count (20) in bits 31:20, and zero in bits 15:5.
- R2: A write to 0x18 stores the low 8 bits as the channel selector, and a read of 0x18 returns it. Offsets 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C reach the selected channel only. If the selector is 20 or more, window reads return 0 and window writes change nothing.
- R3: Channel control at 0x1C has the run bit in bit 0, the reset bit in bit 1, transmit direction in bit 8 and weight in bits 17:16. All other bits read 0. Writing bit 1 as 1 clears that channel's run bit, status, descriptor base and descriptor count at the same clock edge.
- R4: After a control write with bit 1 set, bit 1 of that channel's control reads 1 for exactly 4 cycles and then reads 0.
- R5: Status at 0x28 holds bits 6:1, and bit 0 reads 0. Writing a 1 to a status bit clears it, and writing 0x7E clears all six bits.
- R6: Event input bits [6c+5:6c] set channel c's status bits 6:1 only while that channel's run bit is 1. When an event and a clear hit the same bit in the same cycle, the event wins.
- R7: Interrupt enable at 0x2C holds bits 6:1; bit 3 enables descriptor-complete. The node mask at 0xF4 holds bit n for channel n. The interrupt output is high exactly when some channel n has node bit n set and a nonzero result from status AND enable.
- R8: Writing 0x10 with bit 0 set resets every channel's registers, reset counters included, to zero at that edge. Selectors, node mask and port registers are kept, and 0x10 reads 0.
- R9: A write to 0x40 stores the port selector in bits 7:0. Port control at 0x44 keeps only the endianness-swap field in bits 11:8, packet-drop in bit 6 and the burst fields in bits 5:4 and 3:2 (read mask 0x0F7C). If the selector is 4 or more, 0x44 reads 0 and writes to it are ignored.
- R10: The poll register at 0x14 keeps bit 31 (poll enable) and bit 6 (divide-by-4) only. Descriptor base at 0x20 keeps all 32 bits. Descriptor count at 0x24 keeps bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ch_evt | input | 120 | Six event bits per channel, channel c at [6c+5:6c] |
| irq | output | 1 | Combined interrupt request |

## Verification
The slot and selector state is read straight through the window. A wrong selector, a status bit that failed to clear, or a reset counter that is off by one therefore shows on reg_rdata on the next read, one cycle after the faulty edge. An interrupt-path fault shows on irq in the cycle right after the event or mask write that exposes it. Random traffic mixes out-of-range selectors, overlapping events and clears, and global clears, so a fault in any channel is read back within a few hundred cycles. The bench compares every cycle's read data and irq against a model of all twenty channels.

// File: rtl/dmac_regwin_pkg.sv
`timescale 1ns/1ps
package dmac_regwin_pkg;

    localparam int EVT_W = 6;

    localparam logic [7:0] A_ID    = 8'h08;
    localparam logic [7:0] A_GCTL  = 8'h10;
    localparam logic [7:0] A_POLL  = 8'h14;
    localparam logic [7:0] A_CSEL  = 8'h18;
    localparam logic [7:0] A_CCTL  = 8'h1C;
    localparam logic [7:0] A_DBASE = 8'h20;
    localparam logic [7:0] A_DCNT  = 8'h24;
    localparam logic [7:0] A_STAT  = 8'h28;
    localparam logic [7:0] A_IEN   = 8'h2C;
    localparam logic [7:0] A_PSEL  = 8'h40;
    localparam logic [7:0] A_PCTL  = 8'h44;
    localparam logic [7:0] A_NODE  = 8'hF4;

    localparam logic [31:0] PCTL_MASK = 32'h0000_0F7C;

    typedef enum logic [2:0] {
        W_NONE, W_POLL, W_CTRL, W_BASE, W_CNT, W_STAT, W_IEN
    } win_reg_e;

    typedef struct packed {
        logic [1:0] weight;
        logic       tx_dir;
        logic       run;
    } chan_ctl_t;

    typedef struct packed {
        logic en;
        logic div4;
    } poll_cfg_t;

    function automatic win_reg_e win_decode(input logic [7:0] a);
        case (a)
            A_POLL:  return W_POLL;
            A_CCTL:  return W_CTRL;
            A_DBASE: return W_BASE;
            A_DCNT:  return W_CNT;
            A_STAT:  return W_STAT;
            A_IEN:   return W_IEN;
            default: return W_NONE;
        endcase
    endfunction

    function automatic logic [31:0] pack_ctl(input chan_ctl_t c, input logic busy);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.run;
        w[1]     = busy;
        w[8]     = c.tx_dir;
        w[17:16] = c.weight;
        return w;
    endfunction

    function automatic logic [31:0] pack_poll(input poll_cfg_t p);
        logic [31:0] w;
        w     = '0;
        w[31] = p.en;
        w[6]  = p.div4;
        return w;
    endfunction

    function automatic logic [31:0] id_word(input int nch, input int nport,
                                            input logic [4:0] rev);
        logic [31:0] w;
        w        = '0;
        w[4:0]   = rev;
        w[19:16] = nport[3:0];
        w[31:20] = nch[11:0];
        return w;
    endfunction

endpackage

// File: rtl/dmac_chan_slot.sv
`timescale 1ns/1ps
module dmac_chan_slot
    import dmac_regwin_pkg::*;
#(
    parameter int DCNT_W  = 8,
    parameter int RST_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gclr,
    input  logic                hit,
    input  win_reg_e            wkind,
    input  win_reg_e            rkind,
    input  logic [31:0]         wdata,
    input  logic [EVT_W-1:0]    evt,
    output logic [31:0]         rdata,
    output logic                pend
);

    localparam int CW = $clog2(RST_CYC + 1);

    chan_ctl_t           ctl_q;
    poll_cfg_t           poll_q;
    logic [31:0]         base_q;
    logic [DCNT_W-1:0]   dcnt_q;
    logic [EVT_W-1:0]    stat_q;
    logic [EVT_W-1:0]    ien_q;
    logic [CW-1:0]       rcnt_q;

    win_reg_e            wk;
    logic [EVT_W-1:0]    clr_m;
    logic                busy;

    assign wk    = hit ? wkind : W_NONE;
    assign clr_m = (wk == W_STAT) ? wdata[EVT_W:1] : '0;
    assign busy  = (rcnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || gclr) begin
            ctl_q  <= '0;
            poll_q <= '0;
            base_q <= '0;
            dcnt_q <= '0;
            stat_q <= '0;
            ien_q  <= '0;
            rcnt_q <= '0;
        end else begin
            if (busy) rcnt_q <= rcnt_q - 1'b1;
            stat_q <= (stat_q & ~clr_m) | (ctl_q.run ? evt : '0);
            case (wk)
                W_CTRL: begin
                    ctl_q <= '{weight: wdata[17:16], tx_dir: wdata[8], run: wdata[0]};
                    if (wdata[1]) begin
                        rcnt_q    <= CW'(RST_CYC);
                        ctl_q.run <= 1'b0;
                        stat_q    <= '0;
                        base_q    <= '0;
                        dcnt_q    <= '0;
                    end
                end
                W_POLL: poll_q <= '{en: wdata[31], div4: wdata[6]};
                W_BASE: base_q <= wdata;
                W_CNT:  dcnt_q <= wdata[DCNT_W-1:0];
                W_IEN:  ien_q  <= wdata[EVT_W:1];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (rkind)
                W_POLL: rdata = pack_poll(poll_q);
                W_CTRL: rdata = pack_ctl(ctl_q, busy);
                W_BASE: rdata = base_q;
                W_CNT:  rdata = 32'(dcnt_q);
                W_STAT: rdata = 32'({stat_q, 1'b0});
                W_IEN:  rdata = 32'({ien_q, 1'b0});
                default: rdata = '0;
            endcase
        end
    end

    assign pend = |(stat_q & ien_q);

endmodule

// File: rtl/dmac_port_slot.sv
`timescale 1ns/1ps
module dmac_port_slot
    import dmac_regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hit,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    logic [31:0] pctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            pctl_q <= '0;
        else if (we && hit)
            pctl_q <= wdata & PCTL_MASK;
    end

    assign rdata = hit ? pctl_q : '0;

endmodule

// File: rtl/dmac_irq_merge.sv
`timescale 1ns/1ps
module dmac_irq_merge #(
    parameter int NUM_CH = 20
) (
    input  logic [NUM_CH-1:0] node_en,
    input  logic [NUM_CH-1:0] pend,
    output logic              irq
);

    assign irq = |(node_en & pend);

endmodule

// File: rtl/dmac_regwin.sv
`timescale 1ns/1ps
module dmac_regwin
    import dmac_regwin_pkg::*;
#(
    parameter int         NUM_CH   = 20,
    parameter int         NUM_PORT = 4,
    parameter logic [4:0] REV_ID   = 5'd7,
    parameter int         RST_CYC  = 4,
    parameter int         DCNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [7:0]                reg_addr,
    input  logic                      reg_wr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic [NUM_CH*EVT_W-1:0]   ch_evt,
    output logic                      irq
);

    localparam logic [31:0] ID_VAL = id_word(NUM_CH, NUM_PORT, REV_ID);

    logic [7:0]         csel_q;
    logic [7:0]         psel_q;
    logic [NUM_CH-1:0]  node_en_q;
    logic [NUM_CH-1:0]  pend;
    win_reg_e           rkind;
    win_reg_e           wkind;
    logic               gclr;
    logic [31:0]        ch_rd [NUM_CH];
    logic [31:0]        pt_rd [NUM_PORT];
    logic [31:0]        win_rd;
    logic [31:0]        port_rd;

    assign rkind = win_decode(reg_addr);
    assign wkind = reg_wr ? rkind : W_NONE;
    assign gclr  = reg_wr && (reg_addr == A_GCTL) && reg_wdata[0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = (csel_q == 8'(g));
        dmac_chan_slot #(
            .DCNT_W  (DCNT_W),
            .RST_CYC (RST_CYC)
        ) u_slot (
            .clk   (clk),
            .rst   (rst),
            .gclr  (gclr),
            .hit   (hit),
            .wkind (wkind),
            .rkind (rkind),
            .wdata (reg_wdata),
            .evt   (ch_evt[g*EVT_W +: EVT_W]),
            .rdata (ch_rd[g]),
            .pend  (pend[g])
        );
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        logic hit;
        assign hit = (psel_q == 8'(p));
        dmac_port_slot u_port (
            .clk   (clk),
            .rst   (rst),
            .hit   (hit),
            .we    (reg_wr && (reg_addr == A_PCTL)),
            .wdata (reg_wdata),
            .rdata (pt_rd[p])
        );
    end

    always_comb begin
        win_rd = '0;
        for (int i = 0; i < NUM_CH; i++) win_rd = win_rd | ch_rd[i];
    end

    always_comb begin
        port_rd = '0;
        for (int i = 0; i < NUM_PORT; i++) port_rd = port_rd | pt_rd[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csel_q    <= '0;
            psel_q    <= '0;
            node_en_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CSEL: csel_q    <= reg_wdata[7:0];
                A_PSEL: psel_q    <= reg_wdata[7:0];
                A_NODE: node_en_q <= reg_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            A_ID:    reg_rdata = ID_VAL;
            A_CSEL:  reg_rdata = 32'(csel_q);
            A_PSEL:  reg_rdata = 32'(psel_q);
            A_PCTL:  reg_rdata = port_rd;
            A_NODE:  reg_rdata = 32'(node_en_q);
            default: reg_rdata = win_rd;
        endcase
    end

    dmac_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .node_en (node_en_q),
        .pend    (pend),
        .irq     (irq)
    );

endmodule

// File: rtl/dmac_regwin_chk.sv
`timescale 1ns/1ps
module dmac_regwin_chk
    import dmac_regwin_pkg::*;
#(
    parameter int NUM_CH = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              irq,
    input logic [7:0]        csel_q,
    input logic [NUM_CH-1:0] node_en_q
);

    logic sel_ok;
    logic rst_wr;
    assign sel_ok = (int'(csel_q) < NUM_CH);
    assign rst_wr = reg_wr && (reg_addr == A_CCTL) && reg_wdata[1] && sel_ok;

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_CSEL) |=> $stable(csel_q));

    p_win_oor_r2: assert property (@(posedge clk) disable iff (rst)
        (!sel_ok && win_decode(reg_addr) != W_NONE) |-> (reg_rdata == 32'h0));

    p_rst_off_r3: assert property (@(posedge clk) disable iff (rst)
        rst_wr |=> (reg_addr != A_CCTL || !reg_rdata[0]));

    p_rst_busy_r4: assert property (@(posedge clk) disable iff (rst)
        rst_wr |=> (reg_addr != A_CCTL || reg_rdata[1]));

    p_node_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (node_en_q == '0) |-> !irq);

    p_gclr_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_GCTL && reg_wdata[0]) |=> !irq);

endmodule

bind dmac_regwin dmac_regwin_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .csel_q    (csel_q),
    .node_en_q (node_en_q)
);

// File: tb/dmac_regwin_test.sv
`timescale 1ns/1ps
module dmac_regwin_test;

    localparam int NCH   = 20;
    localparam int NPORT = 4;
    localparam int RSTC  = 4;
    localparam int EVW   = NCH * 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [EVW-1:0]  ch_evt = '0;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dmac_regwin uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_evt(ch_evt), .irq(irq)
    );

    // reference model
    logic        m_on   [NCH];
    logic        m_dir  [NCH];
    logic [1:0]  m_wt   [NCH];
    int          m_busy [NCH];
    logic        m_pe   [NCH];
    logic        m_pd   [NCH];
    logic [31:0] m_base [NCH];
    logic [7:0]  m_cnt  [NCH];
    logic [5:0]  m_stat [NCH];
    logic [5:0]  m_ien  [NCH];
    logic [31:0] m_pctl [NPORT];
    logic [7:0]  m_csel, m_psel;
    logic [NCH-1:0] m_node;

    function automatic void m_clear_ch(input int c);
        m_on[c] = 0; m_dir[c] = 0; m_wt[c] = 0; m_busy[c] = 0; m_pe[c] = 0;
        m_pd[c] = 0; m_base[c] = 0; m_cnt[c] = 0; m_stat[c] = 0; m_ien[c] = 0;
    endfunction

    function automatic void m_reset();
        for (int c = 0; c < NCH; c++) m_clear_ch(c);
        for (int p = 0; p < NPORT; p++) m_pctl[p] = 0;
        m_csel = 0; m_psel = 0; m_node = 0;
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        int c;
        c = int'(m_csel);
        case (a)
            8'h08: return {12'd20, 4'd4, 11'd0, 5'd7};
            8'h18: return {24'd0, m_csel};
            8'h40: return {24'd0, m_psel};
            8'hF4: return {12'd0, m_node};
            8'h44: return (int'(m_psel) < NPORT) ? m_pctl[int'(m_psel)] : 32'h0;
            8'h14, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C: begin
                if (c >= NCH) return 32'h0;
                case (a)
                    8'h14: return {m_pe[c], 24'd0, m_pd[c], 6'd0};
                    8'h1C: return {14'd0, m_wt[c], 7'd0, m_dir[c], 6'd0,
                                   (m_busy[c] > 0), m_on[c]};
                    8'h20: return m_base[c];
                    8'h24: return {24'd0, m_cnt[c]};
                    8'h28: return {25'd0, m_stat[c], 1'b0};
                    default: return {25'd0, m_ien[c], 1'b0};
                endcase
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        logic r;
        r = 0;
        for (int c = 0; c < NCH; c++)
            if (m_node[c] && ((m_stat[c] & m_ien[c]) != 0)) r = 1;
        return r;
    endfunction

    function automatic void m_edge(input logic [7:0] a, input logic we,
                                   input logic [31:0] d, input logic [EVW-1:0] ev);
        for (int c = 0; c < NCH; c++) if (m_busy[c] > 0) m_busy[c]--;
        if (we && a == 8'h10 && d[0]) begin
            for (int c = 0; c < NCH; c++) m_clear_ch(c);
        end else begin
            for (int c = 0; c < NCH; c++) begin
                logic sel;
                logic [5:0] ns;
                sel = we && (int'(m_csel) == c);
                ns = m_stat[c] & ~((sel && a == 8'h28) ? d[6:1] : 6'd0);
                if (m_on[c]) ns = ns | ev[c*6 +: 6];
                if (sel) begin
                    case (a)
                        8'h1C: begin
                            m_on[c] = d[0]; m_dir[c] = d[8]; m_wt[c] = d[17:16];
                            if (d[1]) begin
                                m_busy[c] = RSTC; m_on[c] = 0; ns = 0;
                                m_base[c] = 0; m_cnt[c] = 0;
                            end
                        end
                        8'h14: begin m_pe[c] = d[31]; m_pd[c] = d[6]; end
                        8'h20: m_base[c] = d;
                        8'h24: m_cnt[c] = d[7:0];
                        8'h2C: m_ien[c] = d[6:1];
                        default: ;
                    endcase
                end
                m_stat[c] = ns;
            end
        end
        if (we) begin
            case (a)
                8'h18: m_csel = d[7:0];
                8'h40: m_psel = d[7:0];
                8'hF4: m_node = d[NCH-1:0];
                8'h44: if (int'(m_psel) < NPORT) m_pctl[int'(m_psel)] = d & 32'h0F7C;
                default: ;
            endcase
        end
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h08: return "R1";
            8'h1C: return "R3";
            8'h28: return "R5";
            8'h2C, 8'hF4: return "R7";
            8'h10: return "R8";
            8'h40, 8'h44: return "R9";
            8'h14, 8'h20, 8'h24: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check before the edge, update model at the edge
    task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                        input logic [EVW-1:0] ev, input string tag);
        @(negedge clk);
        reg_addr = a; reg_wr = we; reg_wdata = d; ch_evt = ev;
        #2;
        chk((tag == "") ? tag_of(a) : tag, reg_rdata, m_rd(a));
        chk("R7 irq", {31'd0, irq}, {31'd0, m_irq()});
        @(posedge clk);
        m_edge(a, we, d, ev);
    endtask

    function automatic logic [EVW-1:0] ev_one(input int c, input logic [5:0] v);
        logic [EVW-1:0] e;
        e = '0;
        e[c*6 +: 6] = v;
        return e;
    endfunction

    logic [7:0] alist [13] = '{8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                               8'h28, 8'h2C, 8'h40, 8'h44, 8'hF4, 8'h30};

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 and reset state
        step(8'h08, 0, 0, '0, "R1");
        step(8'h18, 0, 0, '0, "R2");
        step(8'hF4, 0, 0, '0, "R7");

        // R3 control fields on channel 3
        step(8'h18, 1, 32'd3, '0, "R2");
        step(8'h20, 1, 32'hDEAD_BEEF, '0, "R10");
        step(8'h1C, 1, 32'hFFFC_FEFD, '0, "R3");
        step(8'h1C, 0, 0, '0, "R3");

        // R4 self-clearing reset, also clears run and descriptors (R3)
        step(8'h1C, 1, 32'h0001_0103, '0, "R4");
        for (int i = 0; i < RSTC + 2; i++) step(8'h1C, 0, 0, '0, "R4");
        step(8'h20, 0, 0, '0, "R3");

        // R6 event ignored while off
        step(8'h28, 0, 0, ev_one(3, 6'h3F), "R6");
        step(8'h28, 0, 0, '0, "R6");
        step(8'h1C, 1, 32'h1, '0, "R3");
        step(8'h28, 0, 0, ev_one(3, 6'h05), "R6");
        step(8'h28, 0, 0, '0, "R6");
        // clear and event on the same bit: event wins (R6), W1C (R5)
        step(8'h28, 1, 32'h7E, ev_one(3, 6'h04), "R5");
        step(8'h28, 0, 0, '0, "R6");

        // R7 interrupt gating
        step(8'h2C, 1, 32'h08, '0, "R7");
        step(8'h28, 0, 0, '0, "R7");
        step(8'hF4, 1, 32'h8, '0, "R7");
        step(8'hF4, 0, 0, '0, "R7");
        step(8'h28, 1, 32'h7E, '0, "R5");
        step(8'h28, 0, 0, ev_one(3, 6'h04), "R7");
        step(8'h28, 0, 0, '0, "R7");

        // R8 global clear
        step(8'h10, 1, 32'h1, '0, "R8");
        step(8'h10, 0, 0, '0, "R8");
        step(8'h1C, 0, 0, '0, "R8");
        step(8'h18, 0, 0, '0, "R8");

        // R9 port window
        step(8'h40, 1, 32'd1, '0, "R9");
        step(8'h44, 1, 32'hFFFF_FFFF, '0, "R9");
        step(8'h44, 0, 0, '0, "R9");
        step(8'h40, 1, 32'd7, '0, "R9");
        step(8'h44, 1, 32'hFFFF_FFFF, '0, "R9");
        step(8'h40, 1, 32'd1, '0, "R9");
        step(8'h44, 0, 0, '0, "R9");

        // R2 out-of-range selector
        step(8'h18, 1, 32'd20, '0, "R2");
        step(8'h20, 1, 32'h1234_5678, '0, "R2");
        step(8'h20, 0, 0, '0, "R2");
        step(8'h18, 1, 32'd19, '0, "R2");
        step(8'h20, 0, 0, '0, "R2");

        // R10 poll, base and count fields
        step(8'h14, 1, 32'hFFFF_FFFF, '0, "R10");
        step(8'h14, 0, 0, '0, "R10");
        step(8'h24, 1, 32'hFFFF_FFFF, '0, "R10");
        step(8'h24, 0, 0, '0, "R10");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            logic we;
            logic [31:0] d;
            logic [EVW-1:0] ev;
            a  = alist[$urandom % 13];
            we = ($urandom % 2) == 0;
            d  = $urandom;
            case (a)
                8'h18: d = (($urandom % 8) == 0) ? 32'hFF : 32'($urandom % 22);
                8'h40: d = 32'($urandom % 6);
                8'h1C: d = (d & ~32'h2) | ((($urandom % 8) == 0) ? 32'h2 : 32'h0);
                8'h10: d = (d & ~32'h1) | ((($urandom % 16) == 0) ? 32'h1 : 32'h0);
                default: ;
            endcase
            ev = '0;
            for (int c = 0; c < NCH; c++)
                if (($urandom % 4) == 0) ev[c*6 +: 6] = 6'($urandom);
            step(a, we, d, ev, "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule